// File: doc/BRIEF.md
# Commit Thread Selector for a Multithreaded Retire Stage

This block decides which hardware thread may retire the instruction at the head of its reorder buffer in the current commit slot. Each thread presents a 3-bit commit status, a head-ready flag, an empty flag and the sequence number of its head instruction. The block returns a valid flag and a thread index. The selection is combinational, so the retire logic can ask again for each slot within one cycle.

A static configuration input selects the arbitration scheme:

- **Round-robin** scans a registered priority order. A winner is moved to the tail only when the retire logic pulses an accept strobe at a clock edge.
- **Oldest-ready** picks the ready candidate with the smallest head sequence number. A repeated "aggressive" query is oldest-ready mode asked several times.

With one thread configured, arbitration is skipped and only the status decides.

Top module: `commit_thread_pick`

## Requirements
- R1: Status codes 0 (idle), 1 (running) and 4 (waiting on a fetch-side trap) make a thread eligible. Codes 2 (squashing), 3 (trap pending) and 5 to 7 never let a thread be selected.
- R2: With `policy_oldest` = 0, the selector returns the first thread in the priority order that is eligible and has its head ready. The empty flag is not consulted in this mode.
- R3: After reset the priority order is thread 0, 1, ..., N-1, so the lowest ready eligible index wins first.
- R4: A rising clock edge with `grant_take` = 1, `sel_valid` = 1 and `policy_oldest` = 0 moves the selected thread to the tail of the order. All other threads keep their relative order.
- R5: The priority order is unchanged at any edge without an accepted grant, at any edge in oldest-ready mode, and at any edge where `sel_valid` is 0.
- R6: With `policy_oldest` = 1, the candidates are threads that are eligible, head-ready and non-empty. The selector returns the candidate with the smallest head sequence number, compared as unsigned.
- R7: In oldest-ready mode, when candidates have equal sequence numbers, the lowest thread index wins.
- R8: When no thread qualifies, `sel_valid` is 0 and `sel_tid` is 0.
- R9: With one thread configured, `sel_valid` equals the eligibility of that thread's status alone. `sel_tid` is 0 in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_oldest | input | 1 | 0 selects round-robin, 1 selects oldest-ready |
| thr_status | input | 3*NTHR | Per-thread commit status, thread i at bits [3i+2:3i] |
| head_rdy | input | NTHR | Head instruction of thread i is ready to retire |
| rob_empty | input | NTHR | Reorder buffer of thread i holds nothing |
| head_seq | input | SEQW*NTHR | Head sequence number of thread i at [SEQW*i +: SEQW] |
| grant_take | input | 1 | The current selection was used; rotates the order in round-robin mode |
| sel_valid | output | 1 | A thread is selected |
| sel_tid | output | max(1,clog2(NTHR)) | Selected thread index |

## Verification
The bench goes after the following corner cases:

- **Rotation.** A rotation that swapped two entries instead of shifting the rest up would pick the wrong thread two or three grants later. The bench therefore follows long random grant sequences against its own order list.
- **Unused selections.** A design that rotated on an unused selection, or in oldest-ready mode, drifts from the model.
- **Tie-breaks and empty threads.** Equal sequence numbers test the tie rule. An empty but ready thread tests whether the empty flag is ignored in round-robin mode and honoured in oldest-ready mode.
- **Status codes.** Every status code is applied, so a decode that admitted a squashing or trap-pending thread selects a thread that must stay idle.
- **Single thread.** A one-thread instance is swept to show that readiness does not affect its result.

// File: rtl/commit_thread_pick.sv
module commit_thread_pick #(
  parameter int NTHR = 4,
  parameter int SEQW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  policy_oldest,
  input  logic [3*NTHR-1:0]     thr_status,
  input  logic [NTHR-1:0]       head_rdy,
  input  logic [NTHR-1:0]       rob_empty,
  input  logic [SEQW*NTHR-1:0]  head_seq,
  input  logic                  grant_take,
  output logic                  sel_valid,
  output logic [(NTHR>1 ? $clog2(NTHR) : 1)-1:0] sel_tid
);
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1;

  logic [NTHR-1:0]         elig, rr_cand, old_cand;
  logic [NTHR-1:0][TW-1:0] order_q;
  logic                    rr_hit, old_hit;
  logic [TW-1:0]           rr_tid, rr_pos, old_tid;
  logic [SEQW-1:0]         old_seq;

  for (genvar g = 0; g < NTHR; g++) begin : g_elig
    wire [2:0] st = thr_status[3*g +: 3];
    assign elig[g]     = (st == 3'd0) || (st == 3'd1) || (st == 3'd4);
    assign rr_cand[g]  = elig[g] & head_rdy[g];
    assign old_cand[g] = rr_cand[g] & ~rob_empty[g];
  end

  always_comb begin
    rr_hit = 1'b0;
    rr_tid = '0;
    rr_pos = '0;
    for (int p = 0; p < NTHR; p++) begin
      if (!rr_hit && rr_cand[order_q[p]]) begin
        rr_hit = 1'b1;
        rr_tid = order_q[p];
        rr_pos = TW'(p);
      end
    end
  end

  always_comb begin
    old_hit = 1'b0;
    old_tid = '0;
    old_seq = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (old_cand[i] && (!old_hit || head_seq[SEQW*i +: SEQW] < old_seq)) begin
        old_hit = 1'b1;
        old_tid = TW'(i);
        old_seq = head_seq[SEQW*i +: SEQW];
      end
    end
  end

  if (NTHR == 1) begin : g_single
    assign sel_valid = elig[0];
    assign sel_tid   = '0;
  end else begin : g_multi
    assign sel_valid = policy_oldest ? old_hit : rr_hit;
    assign sel_tid   = !sel_valid ? '0 : (policy_oldest ? old_tid : rr_tid);
  end

  wire rotate = grant_take && sel_valid && !policy_oldest && (NTHR > 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) order_q[i] <= TW'(i);
    end else if (rotate) begin
      for (int i = 0; i < NTHR - 1; i++)
        if (TW'(i) >= rr_pos) order_q[i] <= order_q[i+1];
      order_q[NTHR-1] <= rr_tid;
    end
  end

  logic [NTHR-1:0] present;
  logic            older_seen;
  always_comb begin
    present = '0;
    for (int i = 0; i < NTHR; i++) present[order_q[i]] = 1'b1;
    older_seen = 1'b0;
    for (int i = 0; i < NTHR; i++)
      if (old_cand[i] && head_seq[SEQW*i +: SEQW] < head_seq[SEQW*sel_tid +: SEQW])
        older_seen = 1'b1;
  end

  // R1
  sel_status_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (thr_status[3*sel_tid +: 3] inside {3'd0, 3'd1, 3'd4}));

  // R3
  order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(present) == NTHR);

  // R4
  tail_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NTHR > 1 && grant_take && sel_valid && !policy_oldest) |=> order_q[NTHR-1] == $past(sel_tid));

  // R5
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_take && sel_valid && !policy_oldest) |=> $stable(order_q));

  // R6
  oldest_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NTHR > 1 && sel_valid && policy_oldest) |-> !older_seen);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> sel_tid == '0);
endmodule

// File: tb/test_commit_thread_pick.sv
module test_commit_thread_pick;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int SW = 8;

  logic clk = 0, rst_n = 0;
  logic pol = 0, take = 0;
  logic [3*N-1:0]  st = '0;
  logic [N-1:0]    rdy = '0, emp = '0;
  logic [SW*N-1:0] seq = '0;
  logic            vld;
  logic [1:0]      tid;

  logic [2:0] st1 = '0;
  logic       rdy1 = 0, emp1 = 0, vld1;
  logic [0:0] tid1;

  int nchk = 0, nbad = 0;
  int mlist[N];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  commit_thread_pick #(.NTHR(N), .SEQW(SW)) i_commit_thread_pick (
    .clk(clk), .rst_n(rst_n), .policy_oldest(pol), .thr_status(st),
    .head_rdy(rdy), .rob_empty(emp), .head_seq(seq), .grant_take(take),
    .sel_valid(vld), .sel_tid(tid));

  commit_thread_pick #(.NTHR(1), .SEQW(SW)) i_single (
    .clk(clk), .rst_n(rst_n), .policy_oldest(1'b0), .thr_status(st1),
    .head_rdy(rdy1), .rob_empty(emp1), .head_seq('0), .grant_take(1'b0),
    .sel_valid(vld1), .sel_tid(tid1));

  function automatic bit ok_st(logic [2:0] s);
    return s == 0 || s == 1 || s == 4;
  endfunction

  task automatic expect_sel(string req, bit ev, int et);
    nchk++;
    if (vld !== ev || (ev && tid !== 2'(et)) || (!ev && tid !== 0)) begin
      nbad++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               req, vld, tid, ev, ev ? et : 0);
    end
  endtask

  task automatic model(output bit ev, output int et);
    ev = 0; et = 0;
    if (!pol) begin
      for (int p = 0; p < N; p++)
        if (!ev && ok_st(st[3*mlist[p] +: 3]) && rdy[mlist[p]]) begin
          ev = 1; et = mlist[p];
        end
    end else begin
      for (int i = 0; i < N; i++)
        if (ok_st(st[3*i +: 3]) && rdy[i] && !emp[i] &&
            (!ev || seq[SW*i +: SW] < seq[SW*et +: SW])) begin
          ev = 1; et = i;
        end
    end
  endtask

  task automatic step(string req, bit acc);
    bit ev; int et, pos;
    #1;
    model(ev, et);
    expect_sel(req, ev, et);
    take = acc;
    @(posedge clk);
    if (acc && ev && !pol) begin
      pos = 0;
      for (int p = 0; p < N; p++) if (mlist[p] == et) pos = p;
      for (int p = pos; p < N - 1; p++) mlist[p] = mlist[p+1];
      mlist[N-1] = et;
    end
    @(negedge clk);
    take = 0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) mlist[i] = i;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R3: reset order, all ready idle threads -> thread 0
    rdy = '1;
    step("R3", 0);
    // R5: selection unused, still thread 0
    step("R5", 0);
    // R4: accepted grants walk 0,1,2,3,0
    for (int k = 0; k < 5; k++) step("R4", 1);
    // R1: squashing/trap-pending threads skipped, fetch-trap code accepted
    st = {3'd4, 3'd3, 3'd2, 3'd7};
    step("R1", 1);
    step("R1", 1);
    // R2: empty flag ignored in round-robin
    st = '0; emp = '1;
    step("R2", 1);
    // R8: no candidate
    rdy = '0;
    step("R8", 1);
    // R6/R7: oldest-ready, tie and empty handling
    pol = 1; rdy = '1; emp = 4'b0001;
    seq = {8'd5, 8'd5, 8'd9, 8'd1};
    step("R6", 1);
    step("R7", 1);
    seq = {8'd200, 8'd3, 8'd255, 8'd0};
    step("R6", 1);
    // R5: oldest-mode grants did not rotate; back to RR checks order
    pol = 0; emp = '0;
    step("R5", 0);

    // sweep
    for (int k = 0; k < 3000; k++) begin
      pol = $urandom_range(0, 3) == 0;
      for (int i = 0; i < N; i++) st[3*i +: 3] = 3'($urandom_range(0, 7));
      rdy = 4'($urandom); emp = 4'($urandom); seq = 32'($urandom);
      if ($urandom_range(0, 3) == 0) seq[15:8] = seq[7:0];
      step("R2/R4/R6 sweep", $urandom_range(0, 1) == 1);
    end

    // R9: single-thread bypass
    for (int s = 0; s < 8; s++)
      for (int r = 0; r < 4; r++) begin
        st1 = 3'(s); rdy1 = r[0]; emp1 = r[1];
        #1;
        nchk++;
        if (vld1 !== ok_st(3'(s)) || tid1 !== 0) begin
          nbad++;
          $display("FAIL R9: got valid=%0b tid=%0d, expected valid=%0b tid=0",
                   vld1, tid1, ok_st(3'(s)));
        end
        @(negedge clk);
      end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: got hung run, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule